// File: doc/BRIEF.md
# Large-Page NAND Command Sequencer

This block turns one command request into the byte cycles that a large-page NAND device (pages larger than 512 bytes) expects. It drives a command cycle, then two column address cycles and two or three row address cycles. Where the operation calls for it, a confirm command cycle follows the address. It then carries out the post-command wait that belongs to the opcode. That wait is one of three kinds: none, a column-change settle time, or a write-to-busy delay followed by a wait on the device ready line. A request to read the spare area is turned into a normal page read whose column is moved past the end of the page.

Each byte cycle goes to a bus timing unit, which owns the pin-level timing. Each cycle is held on the output until that unit acknowledges it. The block is chosen in place of a small-page sequencer whenever the page size exceeds 512 bytes. Moving data bytes to and from the device is outside its scope.

Top module: `lp_nand_cmd_seq`

## Requirements
- R1: Cycles come out in a fixed order: command (when `req_cmd_en`=1), column low, column high, row low, row middle, row high, confirm. Command and confirm cycles have `bus_is_cmd`=1 and address cycles have `bus_is_cmd`=0. With `req_cmd_en`=0 there is no command cycle, no confirm and no wait.
- R2: A request with opcode 0x50 (spare read) and `req_cmd_en`=1 is sent as opcode 0x00. Its column is `PAGE_BYTES` plus the requested column, or `PAGE_BYTES` alone when `req_col_en`=0, modulo 2^16. The column cycles are always sent.
- R3: Column cycles send the low byte first, then the high byte. For the address-8-bit opcodes 0x90, 0xEC, 0xEE and 0xEF only the low byte is sent.
- R4: With `cfg_bus16`=1 the column, after any spare offset, is shifted right by one before it is sent, except for the address-8-bit opcodes.
- R5: Row cycles are sent low byte first: two cycles, or three when `cfg_row3`=1.
- R6: Opcode 0x00 (or a converted 0x50) with any address cycle is followed by confirm 0x30 and the ready wait. Opcode 0x00 with no address has no confirm and no wait.
- R7: Opcode 0x05 is followed by confirm 0xE0 and then the settle wait; `dev_ready` has no effect on it.
- R8: Opcode 0x85 has no confirm and is followed only by the settle wait.
- R9: The settle wait lasts `cfg_ccs_min` cycles (at least 1) when `cfg_ccs_valid`=1, and `CCS_FALLBACK` cycles otherwise. When `cfg_ccs_en`=0 it is skipped. `seq_done` rises settle+1 cycles after the last bus acknowledge.
- R10: Opcodes 0x15, 0x10, 0x60, 0xD0, 0x80, 0x70, 0x90 and 0xEF finish with no wait: `seq_done` comes one cycle after the last acknowledge.
- R11: Every other opcode, including reset 0xFF, ends with a delay of `TWB_CYCLES` cycles and then waits for `dev_ready`=1. `seq_done` comes max(`TWB_CYCLES`+1, b)+1 cycles after the last acknowledge, where b is the first cycle offset at which `dev_ready` is high.
- R12: A cycle holds its byte and kind until `bus_done`. `req_ready` is high only when idle and no bus cycle is shown then. `seq_done` is a one-cycle pulse followed by idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is high |
| req_ready | output | 1 | Sequencer idle |
| req_cmd_en | input | 1 | Request carries a command byte |
| req_opcode | input | 8 | Command opcode |
| req_col_en | input | 1 | Column address present |
| req_col | input | COL_W | Column address in bytes |
| req_row_en | input | 1 | Row address present |
| req_row | input | ROW_W | Row (page) address |
| cfg_bus16 | input | 1 | Device data bus is 16 bits wide |
| cfg_row3 | input | 1 | Device takes three row cycles |
| cfg_ccs_en | input | 1 | Sequencer must time the column-change settle |
| cfg_ccs_valid | input | 1 | `cfg_ccs_min` holds a usable value |
| cfg_ccs_min | input | CNT_W | Settle time in clock cycles |
| bus_valid | output | 1 | A byte cycle is presented |
| bus_is_cmd | output | 1 | 1 for a command cycle, 0 for an address cycle |
| bus_data | output | 8 | Byte of the cycle |
| bus_done | input | 1 | Bus timing unit finished the presented cycle |
| dev_ready | input | 1 | Device ready line |
| seq_done | output | 1 | One-cycle pulse at the end of the request |

## Verification
The bench goes after the spare-read conversion on both bus widths. A design that forgot the offset, or halved the column before adding it, would send the wrong column bytes. It sends address-8-bit opcodes on a 16-bit bus, where a sequencer that split or halved their column would show an extra cycle or a wrong byte. It drives the ready line low for a long time during random data out: a sequencer that waited on the ready line there would finish late. It also measures how many cycles each wait lasts in its three forms, including the fallback value and the disabled case. A slow acknowledge pattern catches any sequencer that advances without `bus_done`.

// File: rtl/lp_nand_pkg.sv
package lp_nand_pkg;

  localparam logic [7:0] OP_READ0        = 8'h00;
  localparam logic [7:0] OP_READ_SPARE   = 8'h50;
  localparam logic [7:0] OP_READ_CONFIRM = 8'h30;
  localparam logic [7:0] OP_COLOUT       = 8'h05;
  localparam logic [7:0] OP_COLOUT_CONF  = 8'hE0;
  localparam logic [7:0] OP_COLIN        = 8'h85;
  localparam logic [7:0] OP_CACHE_PROG   = 8'h15;
  localparam logic [7:0] OP_PROG         = 8'h10;
  localparam logic [7:0] OP_ERASE_A      = 8'h60;
  localparam logic [7:0] OP_ERASE_B      = 8'hD0;
  localparam logic [7:0] OP_LOAD         = 8'h80;
  localparam logic [7:0] OP_STATUS       = 8'h70;
  localparam logic [7:0] OP_IDENT        = 8'h90;
  localparam logic [7:0] OP_PARAM        = 8'hEC;
  localparam logic [7:0] OP_GETFEAT      = 8'hEE;
  localparam logic [7:0] OP_SETFEAT      = 8'hEF;

  typedef enum logic [1:0] {POST_NONE, POST_CCS, POST_READY} post_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_EMIT, PH_TWB, PH_WRDY, PH_CCS, PH_DONE
  } phase_e;

  localparam int          N_STAGES = 7;
  localparam logic [2:0]  STG_NONE = 3'd7;

  // opcodes whose address phase is a single byte
  function automatic logic addr8_op(input logic [7:0] op);
    return (op == OP_IDENT) || (op == OP_PARAM) ||
           (op == OP_GETFEAT) || (op == OP_SETFEAT);
  endfunction

  function automatic logic no_wait_op(input logic [7:0] op);
    case (op)
      OP_CACHE_PROG, OP_PROG, OP_ERASE_A, OP_ERASE_B,
      OP_LOAD, OP_STATUS, OP_IDENT, OP_SETFEAT: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic post_e post_of(input logic [7:0] op, input logic cmd_en,
                                    input logic has_addr, input logic ccs_en);
    if (!cmd_en)                            return POST_NONE;
    if (no_wait_op(op))                     return POST_NONE;
    if (op == OP_COLIN || op == OP_COLOUT)  return ccs_en ? POST_CCS : POST_NONE;
    if (op == OP_READ0 && !has_addr)        return POST_NONE;
    return POST_READY;
  endfunction

  // lowest enabled stage at or above 'from'; STG_NONE when none is left
  function automatic logic [2:0] next_stage(input logic [N_STAGES-1:0] en,
                                            input logic [3:0] from);
    logic [2:0] r;
    r = STG_NONE;
    for (int i = N_STAGES - 1; i >= 0; i--) begin
      if (en[i] && (i >= int'(from))) r = 3'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/lp_nand_req_prep.sv
module lp_nand_req_prep
  import lp_nand_pkg::*;
#(
  parameter int PAGE_BYTES   = 2048,
  parameter int COL_W        = 16,
  parameter int CNT_W        = 8,
  parameter int CCS_FALLBACK = 50
) (
  input  logic [7:0]          op,
  input  logic                cmd_en,
  input  logic                col_en,
  input  logic [COL_W-1:0]    col,
  input  logic                row_en,
  input  logic                bus16,
  input  logic                row3,
  input  logic                ccs_en,
  input  logic                ccs_valid,
  input  logic [CNT_W-1:0]    ccs_min,
  output logic [7:0]          eff_op,
  output logic [7:0]          conf_op,
  output logic [15:0]         col_out,
  output logic [N_STAGES-1:0] stage_en,
  output post_e               post,
  output logic [CNT_W-1:0]    ccs_len
);

  localparam logic [15:0]      PAGE_OFS = 16'(PAGE_BYTES);
  localparam logic [CNT_W-1:0] FALLBACK = CNT_W'(CCS_FALLBACK);

  logic        spare;
  logic        col_on;
  logic        narrow;
  logic        conf_en;
  logic [15:0] col_base;
  logic [15:0] col_adj;

  always_comb begin
    spare    = cmd_en && (op == OP_READ_SPARE);
    eff_op   = spare ? OP_READ0 : op;
    col_on   = col_en || spare;
    narrow   = addr8_op(eff_op);
    col_base = col_en ? 16'(col) : 16'd0;
    col_adj  = spare ? col_base + PAGE_OFS : col_base;
    col_out  = (bus16 && !narrow) ? (col_adj >> 1) : col_adj;

    conf_en  = cmd_en && ((eff_op == OP_COLOUT) ||
                          ((eff_op == OP_READ0) && (col_on || row_en)));
    conf_op  = (eff_op == OP_COLOUT) ? OP_COLOUT_CONF : OP_READ_CONFIRM;

    stage_en = {conf_en, row_en && row3, row_en, row_en,
                col_on && !narrow, col_on, cmd_en};

    post     = post_of(eff_op, cmd_en, col_on || row_en, ccs_en);

    if (!ccs_valid)          ccs_len = FALLBACK;
    else if (ccs_min == '0)  ccs_len = CNT_W'(1);
    else                     ccs_len = ccs_min;
  end

endmodule

// File: rtl/lp_nand_wait_timer.sv
module lp_nand_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt <= '0;
    else if (load)                 cnt <= (load_val == '0) ? CNT_W'(1) : load_val;
    else if (tick && cnt > CNT_W'(1)) cnt <= cnt - CNT_W'(1);
  end

  assign expired = (cnt <= CNT_W'(1));

endmodule

// File: rtl/lp_nand_cmd_seq.sv
module lp_nand_cmd_seq
  import lp_nand_pkg::*;
#(
  parameter int PAGE_BYTES   = 2048,
  parameter int COL_W        = 16,
  parameter int ROW_W        = 24,
  parameter int CNT_W        = 8,
  parameter int TWB_CYCLES   = 10,
  parameter int CCS_FALLBACK = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_cmd_en,
  input  logic [7:0]       req_opcode,
  input  logic             req_col_en,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_row_en,
  input  logic [ROW_W-1:0] req_row,
  input  logic             cfg_bus16,
  input  logic             cfg_row3,
  input  logic             cfg_ccs_en,
  input  logic             cfg_ccs_valid,
  input  logic [CNT_W-1:0] cfg_ccs_min,
  output logic             bus_valid,
  output logic             bus_is_cmd,
  output logic [7:0]       bus_data,
  input  logic             bus_done,
  input  logic             dev_ready,
  output logic             seq_done
);

  localparam logic [CNT_W-1:0] TWB_LEN = CNT_W'(TWB_CYCLES);

  // request decode
  logic [7:0]          p_op, p_conf;
  logic [15:0]         p_col;
  logic [N_STAGES-1:0] p_en;
  post_e               p_post;
  logic [CNT_W-1:0]    p_ccs;

  lp_nand_req_prep #(
    .PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W),
    .CNT_W(CNT_W), .CCS_FALLBACK(CCS_FALLBACK)
  ) u_prep (
    .op(req_opcode), .cmd_en(req_cmd_en), .col_en(req_col_en), .col(req_col),
    .row_en(req_row_en), .bus16(cfg_bus16), .row3(cfg_row3),
    .ccs_en(cfg_ccs_en), .ccs_valid(cfg_ccs_valid), .ccs_min(cfg_ccs_min),
    .eff_op(p_op), .conf_op(p_conf), .col_out(p_col), .stage_en(p_en),
    .post(p_post), .ccs_len(p_ccs)
  );

  // captured request
  phase_e              phase, phase_d;
  logic [2:0]          stage_q, stage_d;
  logic [N_STAGES-1:0] en_q;
  logic [7:0]          op_q, conf_q;
  logic [15:0]         col_q;
  logic [23:0]         row_q;
  post_e               post_q;
  logic [CNT_W-1:0]    ccs_q;

  // events brought out for the checker
  logic       accept_w;
  logic       hs_w;
  logic       wait_ready_w;
  logic       ccs_wait_w;
  logic [2:0] nxt_w;

  logic             t_load, t_tick, t_exp;
  logic [CNT_W-1:0] t_val;
  post_e            post_sel;
  logic [CNT_W-1:0] ccs_sel;
  logic             go_post;

  assign accept_w     = req_valid && (phase == PH_IDLE);
  assign hs_w         = bus_valid && bus_done;
  assign wait_ready_w = (phase == PH_WRDY);
  assign ccs_wait_w   = (phase == PH_CCS);

  always_comb begin
    phase_d  = phase;
    stage_d  = stage_q;
    go_post  = 1'b0;
    post_sel = (phase == PH_IDLE) ? p_post : post_q;
    ccs_sel  = (phase == PH_IDLE) ? p_ccs : ccs_q;
    t_load   = 1'b0;
    t_val    = '0;
    nxt_w    = STG_NONE;
    case (phase)
      PH_IDLE: if (req_valid) begin
        nxt_w = next_stage(p_en, 4'd0);
        if (nxt_w != STG_NONE) begin
          phase_d = PH_EMIT;
          stage_d = nxt_w;
        end else go_post = 1'b1;
      end
      PH_EMIT: if (bus_done) begin
        nxt_w = next_stage(en_q, {1'b0, stage_q} + 4'd1);
        if (nxt_w != STG_NONE) stage_d = nxt_w;
        else                   go_post = 1'b1;
      end
      PH_TWB:  if (t_exp) phase_d = PH_WRDY;
      PH_WRDY: if (dev_ready) phase_d = PH_DONE;
      PH_CCS:  if (t_exp) phase_d = PH_DONE;
      default: phase_d = PH_IDLE;
    endcase
    if (go_post) begin
      case (post_sel)
        POST_CCS: begin
          phase_d = PH_CCS; t_load = 1'b1; t_val = ccs_sel;
        end
        POST_READY: begin
          phase_d = PH_TWB; t_load = 1'b1; t_val = TWB_LEN;
        end
        default: phase_d = PH_DONE;
      endcase
    end
  end

  assign t_tick = (phase == PH_TWB) || (phase == PH_CCS);

  lp_nand_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
    .tick(t_tick), .expired(t_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      stage_q <= '0;
      en_q    <= '0;
      op_q    <= '0;
      conf_q  <= '0;
      col_q   <= '0;
      row_q   <= '0;
      post_q  <= POST_NONE;
      ccs_q   <= '0;
    end else begin
      phase   <= phase_d;
      stage_q <= stage_d;
      if (accept_w) begin
        en_q   <= p_en;
        op_q   <= p_op;
        conf_q <= p_conf;
        col_q  <= p_col;
        row_q  <= 24'(req_row);
        post_q <= p_post;
        ccs_q  <= p_ccs;
      end
    end
  end

  // byte lanes per stage, in emission order
  logic [7:0] lane [N_STAGES];
  assign lane[0] = op_q;
  assign lane[1] = col_q[7:0];
  assign lane[2] = col_q[15:8];
  assign lane[6] = conf_q;
  for (genvar g = 0; g < 3; g++) begin : g_row
    assign lane[3+g] = row_q[8*g +: 8];
  end

  assign req_ready  = (phase == PH_IDLE);
  assign bus_valid  = (phase == PH_EMIT);
  assign bus_is_cmd = (stage_q == 3'd0) || (stage_q == 3'd6);
  assign bus_data   = (stage_q == STG_NONE) ? 8'h00 : lane[stage_q];
  assign seq_done   = (phase == PH_DONE);

endmodule

// File: rtl/lp_nand_cmd_seq_chk.sv
module lp_nand_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       bus_valid,
  input logic       bus_done,
  input logic       bus_is_cmd,
  input logic [7:0] bus_data,
  input logic       seq_done,
  input logic       dev_ready,
  input logic       wait_ready_w,
  input logic       ccs_wait_w
);

  // R12
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_done |=> bus_valid && $stable(bus_data) && $stable(bus_is_cmd));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_valid && !seq_done);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done && req_ready);

  // R11
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_ready_w && !dev_ready |=> wait_ready_w && !seq_done);

  // R9
  settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ccs_wait_w |-> !bus_valid && !req_ready);

endmodule

bind lp_nand_cmd_seq lp_nand_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .bus_valid(bus_valid),
  .bus_done(bus_done), .bus_is_cmd(bus_is_cmd), .bus_data(bus_data),
  .seq_done(seq_done), .dev_ready(dev_ready),
  .wait_ready_w(wait_ready_w), .ccs_wait_w(ccs_wait_w)
);

// File: tb/test_lp_nand_cmd_seq.sv
module test_lp_nand_cmd_seq;

  localparam int PAGE   = 2048;
  localparam int TWB    = 10;
  localparam int FALLBK = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_cmd_en = 1'b0, req_col_en = 1'b0, req_row_en = 1'b0;
  logic [7:0]  req_opcode = '0;
  logic [15:0] req_col = '0;
  logic [23:0] req_row = '0;
  logic        cfg_bus16 = 1'b0, cfg_row3 = 1'b0, cfg_ccs_en = 1'b0, cfg_ccs_valid = 1'b0;
  logic [7:0]  cfg_ccs_min = '0;
  logic        bus_done = 1'b0, dev_ready = 1'b0;
  logic        req_ready, bus_valid, bus_is_cmd, seq_done;
  logic [7:0]  bus_data;

  int checks = 0;
  int errors = 0;
  int total_cyc = 0;
  logic [8:0] exp_seq [8];
  logic [8:0] got_seq [16];

  always #5 clk = ~clk;

  lp_nand_cmd_seq i_lp_nand_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd_en(req_cmd_en), .req_opcode(req_opcode), .req_col_en(req_col_en),
    .req_col(req_col), .req_row_en(req_row_en), .req_row(req_row),
    .cfg_bus16(cfg_bus16), .cfg_row3(cfg_row3), .cfg_ccs_en(cfg_ccs_en),
    .cfg_ccs_valid(cfg_ccs_valid), .cfg_ccs_min(cfg_ccs_min),
    .bus_valid(bus_valid), .bus_is_cmd(bus_is_cmd), .bus_data(bus_data),
    .bus_done(bus_done), .dev_ready(dev_ready), .seq_done(seq_done)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit b_addr8(input logic [7:0] op);
    return op == 8'h90 || op == 8'hEC || op == 8'hEE || op == 8'hEF;
  endfunction

  function automatic bit b_nowait(input logic [7:0] op);
    return op inside {8'h15, 8'h10, 8'h60, 8'hD0, 8'h80, 8'h70, 8'h90, 8'hEF};
  endfunction

  // 0 none, 1 settle, 2 ready
  function automatic int b_post(input logic [7:0] op, input bit cmd, input bit addr,
                                input bit ccs_en);
    if (!cmd || b_nowait(op)) return 0;
    if (op == 8'h05 || op == 8'h85) return ccs_en ? 1 : 0;
    if (op == 8'h00 && !addr) return 0;
    return 2;
  endfunction

  function automatic int b_ccs(input bit valid, input int mn);
    if (!valid) return FALLBK;
    return (mn == 0) ? 1 : mn;
  endfunction

  task automatic run_txn(input logic [7:0] op, input bit cmd, input bit col_en,
                         input int col, input bit row_en, input int row,
                         input bit b16, input bit r3, input bit ccs_en, input bit ccs_v,
                         input int ccs_mn, input int busy, input int pct, input string tag);
    logic [7:0] eop;
    bit spare, col_on, narrow;
    int c, n_exp, n_got, post, gap_exp, last, k, dcyc;
    bit seen;
    spare  = cmd && op == 8'h50;
    eop    = spare ? 8'h00 : op;
    col_on = col_en || spare;
    narrow = b_addr8(eop);
    c = col_en ? col : 0;
    if (spare) c = c + PAGE;
    c = c % 65536;
    if (b16 && !narrow) c = c / 2;
    n_exp = 0;
    if (cmd) begin exp_seq[n_exp] = {1'b1, eop}; n_exp++; end
    if (col_on) begin
      exp_seq[n_exp] = {1'b0, 8'(c)}; n_exp++;
      if (!narrow) begin exp_seq[n_exp] = {1'b0, 8'(c >> 8)}; n_exp++; end
    end
    if (row_en) begin
      exp_seq[n_exp] = {1'b0, 8'(row)}; n_exp++;
      exp_seq[n_exp] = {1'b0, 8'(row >> 8)}; n_exp++;
      if (r3) begin exp_seq[n_exp] = {1'b0, 8'(row >> 16)}; n_exp++; end
    end
    if (cmd && eop == 8'h05) begin exp_seq[n_exp] = {1'b1, 8'hE0}; n_exp++; end
    else if (cmd && eop == 8'h00 && (col_on || row_en)) begin
      exp_seq[n_exp] = {1'b1, 8'h30}; n_exp++;
    end
    post = b_post(eop, cmd, col_on || row_en, ccs_en);
    if (post == 0)      gap_exp = 1;
    else if (post == 1) gap_exp = b_ccs(ccs_v, ccs_mn) + 1;
    else                gap_exp = ((TWB + 1 > busy) ? TWB + 1 : busy) + 1;

    @(negedge clk);
    check(req_ready === 1'b1, "R12", "ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_cmd_en = cmd; req_opcode = op; req_col_en = col_en;
    req_col = 16'(col); req_row_en = row_en; req_row = 24'(row);
    cfg_bus16 = b16; cfg_row3 = r3; cfg_ccs_en = ccs_en; cfg_ccs_valid = ccs_v;
    cfg_ccs_min = 8'(ccs_mn);
    last = 0; k = 0; n_got = 0; seen = 0; dcyc = 0;
    dev_ready = (n_exp == 0) && (busy == 0);
    while (!seen && k < 600) begin
      @(negedge clk);
      k++;
      req_valid = 1'b0;
      if (seq_done) begin
        seen = 1; dcyc = k; bus_done = 1'b0;
      end else if (bus_valid) begin
        if (($urandom % 100) < pct) begin
          if (n_got < 16) got_seq[n_got] = {bus_is_cmd, bus_data};
          n_got++;
          if (n_got == n_exp) last = k;
          bus_done = 1'b1;
        end else bus_done = 1'b0;
      end else bus_done = 1'b0;
      dev_ready = (n_got >= n_exp) && (k >= last + busy);
    end
    bus_done = 1'b0;
    dev_ready = 1'b0;
    check(seen, tag, "seq_done seen", int'(seen), 1);
    check(n_got == n_exp, tag, "cycle count", n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++)
      check(got_seq[i] == exp_seq[i], tag, $sformatf("cycle %0d", i),
            int'(got_seq[i]), int'(exp_seq[i]));
    if (seen) check(dcyc - last == gap_exp, tag, "done gap", dcyc - last, gap_exp);
  endtask

  function automatic string tag_of(input logic [7:0] op, input bit cmd);
    if (!cmd) return "R1";
    case (op)
      8'h50: return "R2";
      8'h00: return "R6";
      8'h05: return "R7";
      8'h85: return "R8";
      default: return b_nowait(op) ? "R10" : "R11";
    endcase
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      total_cyc++;
      if (total_cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", total_cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] ops [16];
    void'($urandom(32'h1234_5678));
    ops = '{8'h00, 8'h50, 8'h05, 8'h85, 8'h15, 8'h10, 8'h60, 8'hD0,
            8'h80, 8'h70, 8'h90, 8'hEF, 8'hFF, 8'hEC, 8'hEE, 8'h31};
    repeat (4) @(negedge clk);
    check(req_ready === 1'b1 && bus_valid === 1'b0 && seq_done === 1'b0, "R12",
          "reset state", {req_ready, bus_valid, seq_done}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: spare read on 8-bit bus, offset column plus confirm
    run_txn(8'h50, 1, 1, 16, 1, 24'h012345, 0, 0, 1, 1, 5, 4, 100, "R2");
    // R2 R4: spare read on 16-bit bus, column halved after offset
    run_txn(8'h50, 1, 0, 0, 1, 24'h000102, 1, 0, 1, 1, 5, 0, 100, "R4");
    // R3 R4 R10: address-8-bit opcode keeps one unhalved column byte
    run_txn(8'h90, 1, 1, 16'h0120, 0, 0, 1, 0, 1, 1, 5, 0, 100, "R3");
    // R6: page read with no address, no confirm, no wait
    run_txn(8'h00, 1, 0, 0, 0, 0, 0, 0, 1, 1, 5, 0, 100, "R6");
    // R5 R6: three row cycles and a long busy
    run_txn(8'h00, 1, 1, 16'h0abc, 1, 24'hA1B2C3, 0, 1, 1, 1, 5, 20, 100, "R5");
    // R7: ready line held low must not delay random data out
    run_txn(8'h05, 1, 1, 16'h0044, 0, 0, 0, 0, 1, 1, 7, 300, 100, "R7");
    // R8 R9: random data in with fallback settle
    run_txn(8'h85, 1, 1, 16'h0010, 0, 0, 0, 0, 1, 0, 7, 0, 100, "R8");
    // R9: settle disabled, and zero minimum counts as one cycle
    run_txn(8'h85, 1, 1, 16'h0010, 0, 0, 0, 0, 0, 1, 7, 0, 100, "R9");
    run_txn(8'h05, 1, 1, 16'h0010, 0, 0, 0, 0, 1, 1, 0, 0, 100, "R9");
    // R11: reset waits on the ready line
    run_txn(8'hFF, 1, 0, 0, 0, 0, 0, 0, 1, 1, 5, 3, 100, "R11");
    // R1: no command byte, address only, no wait; then nothing at all
    run_txn(8'h00, 0, 1, 16'h0102, 1, 24'h0304, 0, 0, 1, 1, 5, 0, 100, "R1");
    run_txn(8'h00, 0, 0, 0, 0, 0, 0, 0, 1, 1, 5, 0, 100, "R1");
    // R12: slow acknowledges
    run_txn(8'h80, 1, 1, 16'h0777, 1, 24'h00BEEF, 0, 1, 1, 1, 5, 0, 20, "R12");
    // R10: program confirm with no address
    run_txn(8'h10, 1, 0, 0, 0, 0, 0, 0, 1, 1, 5, 0, 100, "R10");

    for (int t = 0; t < 60; t++) begin
      logic [7:0] op;
      bit cmd;
      op  = ops[$urandom % 16];
      cmd = ($urandom % 8) != 0;
      run_txn(op, cmd, 1'($urandom), int'($urandom % 8192), 1'($urandom),
              int'($urandom % 24'hFFFFFF), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), int'($urandom % 20), int'($urandom % 16),
              40 + int'($urandom % 61), tag_of(op, cmd));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule